// File: doc/BRIEF.md
# Epoch-Ordered Persistence Write-Back Tracker

This block sits beside a cache and keeps the tags that decide when a line may travel to persistent memory. Every store carries a line index and a flag saying whether the line targets persistent memory. Software splits its stores into epochs with an explicit barrier pulse. Each line records a dirty bit, a persistent bit and a 3-bit epoch number. A circular table of eight epoch slots counts the dirty persistent lines of each in-flight epoch.

The tracker issues write-backs over a request/acknowledge handshake. It keeps one rule: no persistent line of an epoch reaches memory while a persistent line of an older epoch is still dirty. An eviction or a conflicting store first drains the older epochs, oldest epoch first and ascending line index within an epoch, and then writes the line itself. When software asks for a ninth epoch, the tracker drains the oldest epoch itself. The oldest epoch retires as soon as its count reaches zero. While the tracker is working it raises `stall`, and it drops any command that arrives during that time.

Top module: `epoch_persist_tracker`

## Requirements
- R1: After reset `stall` and `wb_req` are low and every line is clean.
- R2: A store that does not meet a dirty persistent line of an older epoch is absorbed in one cycle: no write-back and no stall. The line becomes dirty, takes the current epoch and gets persistent bit = `st_pers`. If the line was already dirty and persistent, its persistent bit stays set.
- R3: A barrier accepted while at least one of the eight epoch slots is free advances the current epoch by one, with no stall.
- R4: Evicting a dirty line whose persistent bit is clear writes back only that line, whatever other lines are dirty.
- R5: Evicting a dirty persistent line first writes back every dirty persistent line of older epochs, ordered by epoch age (oldest first) and then by ascending line index, and then writes back the line itself.
- R6: A store to a line that is dirty, persistent and tagged with an older epoch first writes the line back, with the R5 ordering. The store is then applied, tagging the line with the current epoch.
- R7: A barrier that arrives while all eight slots are busy raises `stall`. The tracker writes back the oldest epoch's dirty persistent lines in ascending index order, and the barrier then takes effect.
- R8: `wb_req` stays high, with `wb_line` stable, until the cycle in which `wb_ack` is sampled high. After that cycle the line is clean.
- R9: A store, barrier or eviction presented while `stall` is high has no effect.
- R10: When several commands arrive in one cycle, only one is accepted. A store wins over a barrier, and a barrier wins over an eviction.
- R11: Evicting a clean line does nothing: no write-back and no stall.
- R12: An epoch holding no dirty persistent line retires one cycle after it stops being the newest epoch, so a run of barriers without persistent stores never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store tag command |
| st_line | input | LW | Line index of the store |
| st_pers | input | 1 | Store targets persistent memory |
| bar | input | 1 | Epoch barrier pulse |
| ev_valid | input | 1 | Eviction request |
| ev_line | input | LW | Line index to evict |
| wb_req | output | 1 | Write-back request toward memory |
| wb_line | output | LW | Line being written back |
| wb_ack | input | 1 | Memory accepted the write-back |
| stall | output | 1 | Tracker busy; commands are dropped |

## Verification
The bench keeps epochs as unbounded integers, so it exercises the wrap of the 3-bit pointers without sharing that arithmetic. Several corner cases are targeted:
- An eviction two epochs deep. A design that ignored age would write the target first.
- Persistent lines stored in descending index order. An ordering bug would drain them in store order.
- A conflicting store in a newer epoch. A design that retagged without flushing would later drain the line with the wrong epoch.
- A ninth barrier. A design without the drain would deadlock and trip the watchdog.
- A long run of empty barriers. A design without eager retirement would stall.
- Commands dropped during a stall, and commands that collide in one cycle. A design that obeyed the wrong command would produce write-backs the model does not expect.

// File: rtl/epoch_persist_tracker.sv
module epoch_persist_tracker #(
  parameter int LINES = 16,
  parameter int EW    = 3,
  localparam int LW   = $clog2(LINES),
  localparam int NEP  = 1 << EW,
  localparam int CW   = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [LW-1:0] st_line,
  input  logic          st_pers,
  input  logic          bar,
  input  logic          ev_valid,
  input  logic [LW-1:0] ev_line,
  output logic          wb_req,
  output logic [LW-1:0] wb_line,
  input  logic          wb_ack,
  output logic          stall
);

  typedef enum logic [1:0] {IDLE, FLUSH, BARD} st_t;

  st_t             st;
  logic [LINES-1:0] dty, prs;
  logic [EW-1:0]   tag [LINES];
  logic [CW-1:0]   cnt [NEP];
  logic [EW-1:0]   cur, old;
  logic [LW-1:0]   tgt;
  logic            tgt_st, tgt_p;
  logic            wb_req_q;
  logic [LW-1:0]   wb_line_q;

  logic            full, ret, conflict;
  logic            acc_st, acc_bar, acc_ev;
  logic [EW-1:0]   bnd;
  logic            vfound;
  logic [LW-1:0]   vline;
  logic [EW-1:0]   vage;
  logic            issue_en, done_f, bar_go, ap_en, ap_p, ack_hit;
  logic [LW-1:0]   issue_line, ap_line;
  logic [CW-1:0]   wb_cnt;

  assign full     = (cur + EW'(1)) == old;
  assign ret      = (old != cur) && (cnt[old] == '0);
  assign conflict = dty[st_line] && prs[st_line] && (tag[st_line] != cur);
  assign acc_st   = (st == IDLE) && st_valid;
  assign acc_bar  = (st == IDLE) && !st_valid && bar;
  assign acc_ev   = (st == IDLE) && !st_valid && !bar && ev_valid;
  assign ack_hit  = wb_req_q && wb_ack;
  assign wb_cnt   = cnt[tag[wb_line_q]];

  always_comb begin
    if (st == BARD) bnd = EW'(1);
    else if (prs[tgt]) bnd = tag[tgt] - old;
    else bnd = '0;
  end

  always_comb begin
    vfound = 1'b0;
    vline  = '0;
    vage   = '1;
    for (int i = 0; i < LINES; i++) begin
      logic [EW-1:0] a;
      a = tag[i] - old;
      if (dty[i] && prs[i] && (a < bnd) && (!vfound || (a < vage))) begin
        vfound = 1'b1;
        vage   = a;
        vline  = LW'(i);
      end
    end
  end

  assign issue_en   = !wb_req_q && (((st == FLUSH) && (vfound || dty[tgt])) ||
                                    ((st == BARD) && full && vfound));
  assign issue_line = vfound ? vline : tgt;
  assign done_f     = (st == FLUSH) && !wb_req_q && !vfound && !dty[tgt];
  assign bar_go     = (st == BARD) && !wb_req_q && !full;
  assign ap_en      = (acc_st && !conflict) || (done_f && tgt_st);
  assign ap_line    = (st == IDLE) ? st_line : tgt;
  assign ap_p       = (st == IDLE) ? st_pers : tgt_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      dty       <= '0;
      prs       <= '0;
      cur       <= '0;
      old       <= '0;
      tgt       <= '0;
      tgt_st    <= 1'b0;
      tgt_p     <= 1'b0;
      wb_req_q  <= 1'b0;
      wb_line_q <= '0;
      for (int i = 0; i < LINES; i++) tag[i] <= '0;
      for (int e = 0; e < NEP; e++) cnt[e] <= '0;
    end else begin
      if (ret) old <= old + EW'(1);

      if (ack_hit) begin
        wb_req_q        <= 1'b0;
        dty[wb_line_q]  <= 1'b0;
        prs[wb_line_q]  <= 1'b0;
        if (prs[wb_line_q]) cnt[tag[wb_line_q]] <= wb_cnt - CW'(1);
      end

      if (issue_en) begin
        wb_req_q  <= 1'b1;
        wb_line_q <= issue_line;
      end

      if (ap_en) begin
        dty[ap_line] <= 1'b1;
        tag[ap_line] <= cur;
        if (!(dty[ap_line] && prs[ap_line])) begin
          prs[ap_line] <= ap_p;
          if (ap_p) cnt[cur] <= cnt[cur] + CW'(1);
        end
      end

      if ((acc_bar && !full) || bar_go) cur <= cur + EW'(1);

      case (st)
        IDLE: begin
          if (acc_st && conflict) begin
            st     <= FLUSH;
            tgt    <= st_line;
            tgt_st <= 1'b1;
            tgt_p  <= st_pers;
          end else if (acc_bar && full) begin
            st <= BARD;
          end else if (acc_ev && dty[ev_line]) begin
            st     <= FLUSH;
            tgt    <= ev_line;
            tgt_st <= 1'b0;
          end
        end
        FLUSH: if (done_f) st <= IDLE;
        BARD:  if (bar_go) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign wb_req  = wb_req_q;
  assign wb_line = wb_line_q;
  assign stall   = (st != IDLE);

endmodule

// File: rtl/epoch_persist_checker.sv
module epoch_persist_checker #(
  parameter int LINES = 16,
  parameter int EW    = 3,
  localparam int LW   = $clog2(LINES),
  localparam int CW   = $clog2(LINES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_valid,
  input logic             bar,
  input logic             stall,
  input logic             wb_req,
  input logic             wb_ack,
  input logic [LW-1:0]    wb_line,
  input logic [EW-1:0]    cur,
  input logic [EW-1:0]    old,
  input logic             full,
  input logic [LINES-1:0] prs,
  input logic [CW-1:0]    wb_cnt
);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_line)));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> !wb_req);

  a_r12_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
    (old != $past(old)) |-> ((old - $past(old)) == EW'(1)));

  a_r5_counted_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack && prs[wb_line]) |-> (wb_cnt != '0));

  a_r3_bar_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (bar && !st_valid && !stall && !full) |=> ((cur - $past(cur)) == EW'(1)));

  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bar && !st_valid && !stall && full) |=> stall);

endmodule

bind epoch_persist_tracker epoch_persist_checker #(.LINES(LINES), .EW(EW)) i_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .bar(bar), .stall(stall),
  .wb_req(wb_req), .wb_ack(wb_ack), .wb_line(wb_line), .cur(cur), .old(old),
  .full(full), .prs(prs), .wb_cnt(wb_cnt));

// File: tb/test_epoch_persist_tracker.sv
`timescale 1ns/1ps
module test_epoch_persist_tracker;
  localparam int LINES = 16;
  localparam int LW = 4;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, st_pers = 0, bar = 0, ev_valid = 0, wb_ack = 0;
  logic [LW-1:0] st_line = '0, ev_line = '0;
  logic wb_req, stall;
  logic [LW-1:0] wb_line;

  epoch_persist_tracker #(.LINES(LINES)) i_epoch_persist_tracker (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_line(st_line),
    .st_pers(st_pers), .bar(bar), .ev_valid(ev_valid), .ev_line(ev_line),
    .wb_req(wb_req), .wb_line(wb_line), .wb_ack(wb_ack), .stall(stall));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int mdty[LINES], mprs[LINES], mep[LINES];
  int mcur = 0;
  int expq[$];
  int dly = 0, ackn = 0;
  logic done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void mflush(input int l);
    if (!mdty[l]) return;
    if (mprs[l])
      for (int e = 0; e < mep[l]; e++)
        for (int i = 0; i < LINES; i++)
          if (mdty[i] && mprs[i] && mep[i] == e) begin
            expq.push_back(i); mdty[i] = 0; mprs[i] = 0;
          end
    expq.push_back(l); mdty[l] = 0; mprs[l] = 0;
  endfunction

  function automatic int moldest();
    int o = mcur;
    for (int i = 0; i < LINES; i++)
      if (mdty[i] && mprs[i] && mep[i] < o) o = mep[i];
    return o;
  endfunction

  function automatic void mstore(input int l, input int p);
    if (mdty[l] && mprs[l] && mep[l] < mcur) mflush(l);
    if (!(mdty[l] && mprs[l])) mprs[l] = p;
    mdty[l] = 1; mep[l] = mcur;
  endfunction

  function automatic void mbar();
    int o = moldest();
    if (mcur - o == 7)
      for (int i = 0; i < LINES; i++)
        if (mdty[i] && mprs[i] && mep[i] == o) begin
          expq.push_back(i); mdty[i] = 0; mprs[i] = 0;
        end
    mcur++;
  endfunction

  // responder and per-clock comparison against the model queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wb_ack) begin
        wb_ack = 0;
        if (expq.size() > 0) void'(expq.pop_front());
      end else if (wb_req) begin
        chk(expq.size() > 0, "R8 unexpected write-back", wb_line, -1);
        if (expq.size() > 0)
          chk(wb_line == expq[0], "R5 write-back order", wb_line, expq[0]);
        if (dly == 0) begin
          wb_ack = 1; ackn++; dly = (ackn * 3) % 4;
        end else dly--;
      end
    end
  end

  task automatic wait_idle(input string req);
    while (stall) @(negedge clk);
    @(negedge clk);
    chk(expq.size() == 0, req, expq.size(), 0);
    chk(!wb_req, req, wb_req, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic issue(input bit s, input int sl, input bit sp, input bit b,
                       input bit e, input int el, input string req);
    chk(!stall, req, stall, 0);
    st_valid = s; st_line = LW'(sl); st_pers = sp; bar = b;
    ev_valid = e; ev_line = LW'(el);
    if (s) mstore(sl, sp);
    else if (b) mbar();
    else if (e) mflush(el);
    @(negedge clk);
    st_valid = 0; bar = 0; ev_valid = 0;
    chk(stall == (expq.size() > 0), req, stall, expq.size() > 0);
    wait_idle(req);
  endtask

  task automatic store(input int l, input bit p, input string req);
    issue(1, l, p, 0, 0, 0, req);
  endtask
  task automatic barrier(input string req);
    issue(0, 0, 0, 1, 0, 0, req);
  endtask
  task automatic evict(input int l, input string req);
    issue(0, 0, 0, 0, 1, l, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin mdty[i] = 0; mprs[i] = 0; mep[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!stall, "R1 stall after reset", stall, 0);
    chk(!wb_req, "R1 wb_req after reset", wb_req, 0);

    store(5, 1, "R2 store"); store(3, 1, "R2 store"); store(7, 0, "R2 store");
    barrier("R3 barrier");
    store(2, 1, "R2 store"); store(1, 1, "R2 store");
    barrier("R3 barrier");
    store(0, 1, "R2 store");
    evict(0, "R5 ordered eviction");
    evict(7, "R4 non-persistent eviction");
    evict(7, "R11 clean eviction");

    store(4, 1, "R2 store");
    barrier("R3 barrier");
    store(4, 1, "R6 conflicting store");
    store(6, 1, "R2 store");
    barrier("R3 barrier");
    store(8, 1, "R2 store");
    evict(8, "R6 retagged line drains in new epoch");

    issue(1, 9, 1, 0, 1, 9, "R10 store beats eviction");
    issue(0, 0, 0, 1, 1, 9, "R10 barrier beats eviction");
    evict(9, "R10 line still dirty");

    for (int k = 0; k < 10; k++) barrier("R12 empty epochs retire");

    store(11, 1, "R2 store"); store(10, 1, "R2 store");
    barrier("R3 barrier"); barrier("R3 barrier");
    store(13, 1, "R2 store");
    for (int k = 0; k < 5; k++) barrier("R3 barrier");
    barrier("R7 full barrier drains oldest");
    evict(13, "R7 survivor drains later");

    store(14, 0, "R2 store");
    chk(!stall, "R9 precondition", stall, 0);
    ev_valid = 1; ev_line = LW'(14); mflush(14);
    @(negedge clk);
    ev_valid = 0;
    chk(stall, "R9 busy", stall, 1);
    st_valid = 1; st_line = LW'(9); st_pers = 1; bar = 1;
    @(negedge clk);
    st_valid = 0; bar = 0;
    wait_idle("R9 drain");
    evict(9, "R9 store during stall ignored");
    barrier("R9 barrier during stall ignored");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule